// File: doc/BRIEF.md
# Scanline Timer with CPU Stall

This block paces one horizontal line of a retro video chip. It runs on the color clock and divides it by three to give the processor a one-clock-wide enable once per CPU cycle. A line lasts 76 CPU cycles (228 color clocks). A shift-register sequence tracks position within the line, and a one-clock flag marks the start of each new line, which is also the start of horizontal blank.

The processor can ask to be held until the next line begins. It does this by writing the sync address through the register port. The write is taken at the last color clock of the CPU cycle that carries it. From the next color clock the ready output is held low, and it rises again when the line wraps. If the write and the wrap fall on the same edge, the set wins. The processor then loses the whole following line.

The stall logic is a two-state machine. `ST_RUN` (ready high) moves to `ST_STALL` on a qualified sync write, named transition SYNC_SET. `ST_STALL` returns to `ST_RUN` on a line wrap that has no coincident sync write, named transition LINE_RELEASE. A wrap that has a coincident write keeps the machine in `ST_STALL`, named transition LATE_HOLD. Reset forces `ST_RUN`.

Top module: `line_timer`

## Requirements
- R1: After synchronous reset, `cpu_rdy` is 1, `cpu_cycle` is 0, `line_pos` equals the seed 6'h01 and `cpu_ce` is 0. The first `cpu_ce` occurs in the third color clock after reset.
- R2: `cpu_ce` is high for exactly one color clock in every three, in color clocks k with k mod 3 = 2, counted from reset.
- R3: `cpu_cycle` advances on each `cpu_ce` edge through 0..75 and then returns to 0. It equals (k/3) mod 76, so a line is 228 color clocks.
- R4: `line_pos` holds each value for four color clocks and takes 57 distinct nonzero values per line. It equals the seed 6'h01 in the first color clock of every line.
- R5: `blank_start` is high for exactly the first color clock of each line after the first, that is for k > 0 with k mod 228 = 0. It is low otherwise.
- R6: A sync write is `bus_sel`=1, `bus_rw_n`=0 and `bus_addr`=6'h02, present in the last color clock of CPU cycle c. When c < 75, it drives `cpu_rdy` low for exactly 3*(75-c) color clocks. `cpu_rdy` rises in the color clock where `blank_start` is high.
- R7: A sync write in cycle 75 drives `cpu_rdy` low for the whole next line, 228 color clocks. It is released at the following line start.
- R8: A read of address 6'h02 (`bus_rw_n`=1), or a write to any other address, leaves `cpu_rdy` high.
- R9: The bus is sampled only in the last color clock of a CPU cycle. A sync write that is present only in the first two color clocks of a cycle has no effect on `cpu_rdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Color clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_rw_n | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 6 | Register address |
| cpu_ce | output | 1 | CPU clock enable, one color clock in three |
| cpu_rdy | output | 1 | Processor ready, low while stalled |
| line_pos | output | 6 | Shift-register line position |
| blank_start | output | 1 | One-clock pulse at each line start |
| cpu_cycle | output | 7 | CPU cycle within the line, 0..75 |

## Verification
The bench builds the block with its default parameters: divide by 3, 76 cycles per line, a prescale of 4, 57 sequence steps and sync address 6'h02. At these values, every CPU cycle of a line can be tried as the write point. The bench sweeps all 76 cycles for sync writes and for reads, which brings the early, late and coincident-with-wrap stall lengths within reach. Two full lines after reset are checked color clock by color clock for enable phase, cycle count, sequence distinctness and blank pulses.

// File: rtl/line_timer_pkg.sv
package line_timer_pkg;

    localparam int LFSR_W = 6;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_STALL = 1'b1
    } stall_state_t;

    // Maximal-length 6-bit sequence, taps at bits 5 and 4
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_W-2]};
    endfunction

endpackage

// File: rtl/cpu_phase_div.sv
module cpu_phase_div #(
    parameter int PH_DIV = 3,
    parameter int CYCLES = 76
) (
    input  logic                      clk,
    input  logic                      rst,
    output logic                      cpu_ce,
    output logic [$clog2(CYCLES)-1:0] cpu_cycle
);
    localparam int PH_W  = $clog2(PH_DIV);
    localparam int CYC_W = $clog2(CYCLES);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(PH_DIV - 1);
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYCLES - 1);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst)                 phase <= '0;
        else if (phase == PH_LAST) phase <= '0;
        else                     phase <= phase + 1'b1;
    end

    always_comb cpu_ce = (phase == PH_LAST);

    always_ff @(posedge clk) begin
        if (rst)                          cpu_cycle <= '0;
        else if (cpu_ce && cpu_cycle == CYC_LAST) cpu_cycle <= '0;
        else if (cpu_ce)                  cpu_cycle <= cpu_cycle + 1'b1;
    end

    AST_CE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cpu_ce |=> !cpu_ce); // R2
    AST_CYCLE_RANGE: assert property (@(posedge clk) disable iff (rst)
        cpu_cycle <= CYC_LAST); // R3
    AST_CYCLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cpu_ce |=> $stable(cpu_cycle)); // R3

endmodule

// File: rtl/line_lfsr.sv
module line_lfsr
    import line_timer_pkg::*;
#(
    parameter int              QUAD  = 4,
    parameter int              STEPS = 57,
    parameter logic [LFSR_W-1:0] SEED = 6'h01
) (
    input  logic              clk,
    input  logic              rst,
    output logic [LFSR_W-1:0] line_pos,
    output logic              line_wrap,
    output logic              blank_start
);
    localparam int Q_W = $clog2(QUAD);
    localparam logic [Q_W-1:0] Q_LAST = Q_W'(QUAD - 1);

    function automatic logic [LFSR_W-1:0] seq_end();
        logic [LFSR_W-1:0] s;
        s = SEED;
        for (int i = 0; i < STEPS - 1; i++) s = lfsr_step(s);
        return s;
    endfunction

    localparam logic [LFSR_W-1:0] POS_LAST = seq_end();

    logic [Q_W-1:0] quad;
    logic           step;

    always_ff @(posedge clk) begin
        if (rst) quad <= '0;
        else     quad <= quad + 1'b1;
    end

    always_comb begin
        step      = (quad == Q_LAST);
        line_wrap = step && (line_pos == POS_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst)            line_pos <= SEED;
        else if (line_wrap) line_pos <= SEED;
        else if (step)      line_pos <= lfsr_step(line_pos);
    end

    always_ff @(posedge clk) begin
        if (rst) blank_start <= 1'b0;
        else     blank_start <= line_wrap;
    end

    AST_POS_NONZERO: assert property (@(posedge clk) disable iff (rst)
        line_pos != '0); // R4
    AST_POS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(line_pos)); // R4
    AST_BLANK_ONE: assert property (@(posedge clk) disable iff (rst)
        blank_start |=> !blank_start); // R5
    AST_BLANK_SEED: assert property (@(posedge clk) disable iff (rst)
        blank_start |-> line_pos == SEED); // R4

endmodule

// File: rtl/stall_fsm.sv
module stall_fsm
    import line_timer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cpu_ce,
    input  logic sync_wr,
    input  logic line_wrap,
    output logic cpu_rdy
);
    stall_state_t state, state_nx;
    logic         set_req;

    always_comb set_req = cpu_ce && sync_wr;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= state_nx;
    end

    // Transitions: SYNC_SET, LINE_RELEASE, LATE_HOLD (set wins on coincidence)
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:   if (set_req)                state_nx = ST_STALL;
            ST_STALL: if (line_wrap && !set_req)  state_nx = ST_RUN;
            default:                              state_nx = ST_RUN;
        endcase
    end

    always_comb cpu_rdy = (state == ST_RUN);

    AST_SET_LOW: assert property (@(posedge clk) disable iff (rst)
        set_req |=> !cpu_rdy); // R6
    AST_WRAP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (line_wrap && !set_req) |=> cpu_rdy); // R6
    AST_LATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (line_wrap && set_req) |=> !cpu_rdy); // R7
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (cpu_rdy && !set_req) |=> cpu_rdy); // R8
    AST_STALL_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!cpu_rdy && !line_wrap) |=> !cpu_rdy); // R6

endmodule

// File: rtl/line_timer.sv
module line_timer
    import line_timer_pkg::*;
#(
    parameter int              PH_DIV    = 3,
    parameter int              CYCLES    = 76,
    parameter int              QUAD      = 4,
    parameter int              STEPS     = 57,
    parameter logic [LFSR_W-1:0] SEED    = 6'h01,
    parameter int              ADDR_W    = 6,
    parameter logic [ADDR_W-1:0] SYNC_ADDR = 6'h02
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_sel,
    input  logic                      bus_rw_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    output logic                      cpu_ce,
    output logic                      cpu_rdy,
    output logic [LFSR_W-1:0]         line_pos,
    output logic                      blank_start,
    output logic [$clog2(CYCLES)-1:0] cpu_cycle
);
    localparam int CYC_W = $clog2(CYCLES);
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYCLES - 1);

    logic line_wrap;
    logic sync_wr;

    always_comb sync_wr = bus_sel && !bus_rw_n && (bus_addr == SYNC_ADDR);

    cpu_phase_div #(.PH_DIV(PH_DIV), .CYCLES(CYCLES)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .cpu_ce    (cpu_ce),
        .cpu_cycle (cpu_cycle)
    );

    line_lfsr #(.QUAD(QUAD), .STEPS(STEPS), .SEED(SEED)) u_lfsr (
        .clk         (clk),
        .rst         (rst),
        .line_pos    (line_pos),
        .line_wrap   (line_wrap),
        .blank_start (blank_start)
    );

    stall_fsm u_stall (
        .clk       (clk),
        .rst       (rst),
        .cpu_ce    (cpu_ce),
        .sync_wr   (sync_wr),
        .line_wrap (line_wrap),
        .cpu_rdy   (cpu_rdy)
    );

    AST_WRAP_ALIGN: assert property (@(posedge clk) disable iff (rst)
        line_wrap |-> (cpu_ce && cpu_cycle == CYC_LAST)); // R3
    AST_CYCLE_END_WRAPS: assert property (@(posedge clk) disable iff (rst)
        (cpu_ce && cpu_cycle == CYC_LAST) |-> line_wrap); // R3
    AST_READ_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cpu_rdy && bus_rw_n) |=> cpu_rdy); // R8

endmodule

// File: tb/tb_line_timer.sv
module tb_line_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_rw_n = 1'b1;
    logic [5:0] bus_addr = 6'h00;
    logic       cpu_ce, cpu_rdy, blank_start;
    logic [5:0] line_pos;
    logic [6:0] cpu_cycle;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    line_timer dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rw_n(bus_rw_n),
        .bus_addr(bus_addr), .cpu_ce(cpu_ce), .cpu_rdy(cpu_rdy),
        .line_pos(line_pos), .blank_start(blank_start), .cpu_cycle(cpu_cycle)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic align_line();
        while (!blank_start) @(negedge clk);
    endtask

    task automatic bus_cycle(input int c, input bit rw_n, input logic [5:0] a, input int held);
        align_line();
        repeat (3 * c) @(negedge clk);
        bus_sel = 1'b1; bus_rw_n = rw_n; bus_addr = a;
        repeat (held) @(negedge clk);
        bus_sel = 1'b0; bus_rw_n = 1'b1; bus_addr = 6'h00;
        repeat (3 - held) @(negedge clk);
    endtask

    task automatic count_low(input int span, output int n);
        n = 0;
        for (int i = 0; i < span; i++) begin
            if (!cpu_rdy) n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit seen [64];
        int dup;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(cpu_rdy == 1'b1, "R1 rdy", cpu_rdy, 1);
        check(cpu_cycle == 7'd0, "R1 cycle", cpu_cycle, 0);
        check(line_pos == 6'h01, "R1 seed", line_pos, 1);
        check(cpu_ce == 1'b0, "R1 ce", cpu_ce, 0);
        dup = 0;
        for (int k = 0; k < 456; k++) begin
            if (k % 228 == 0) begin
                for (int i = 0; i < 64; i++) seen[i] = 1'b0;
                dup = 0;
                check(line_pos == 6'h01, "R4 seed at line start", line_pos, 1);
            end
            check(cpu_ce == (k % 3 == 2), "R2 ce phase", cpu_ce, (k % 3 == 2));
            check(int'(cpu_cycle) == (k / 3) % 76, "R3 cycle", cpu_cycle, (k / 3) % 76);
            check(blank_start == (k > 0 && k % 228 == 0), "R5 blank", blank_start,
                  (k > 0 && k % 228 == 0));
            if (k % 4 == 0) begin
                if (seen[line_pos] || line_pos == 6'h00) dup++;
                seen[line_pos] = 1'b1;
            end
            if (k % 228 == 227) check(dup == 0, "R4 distinct", dup, 0);
            @(negedge clk);
        end
        // R6 / R7 sync write in every cycle
        for (int c = 0; c < 76; c++) begin
            int n;
            int exp;
            exp = (c == 75) ? 228 : 3 * (75 - c);
            bus_cycle(c, 1'b0, 6'h02, 3);
            n = 0;
            while (!cpu_rdy && n < 600) begin n++; @(negedge clk); end
            check(n == exp, (c == 75) ? "R7 stall length" : "R6 stall length", n, exp);
            check(blank_start == 1'b1, "R6 release at line start", blank_start, 1);
        end
        // R8 reads of the sync address
        for (int c = 0; c < 76; c++) begin
            int n;
            bus_cycle(c, 1'b1, 6'h02, 3);
            count_low(240, n);
            check(n == 0, "R8 read ignored", n, 0);
        end
        // R8 writes to other addresses
        for (int a = 0; a < 64; a += 7) begin
            int n;
            if (a == 2) continue;
            bus_cycle(a % 76, 1'b0, 6'(a), 3);
            count_low(240, n);
            check(n == 0, "R8 other address", n, 0);
        end
        // R9 write present only in the first two color clocks of a cycle
        for (int c = 0; c < 76; c += 25) begin
            int n;
            bus_cycle(c, 1'b0, 6'h02, 2);
            count_low(240, n);
            check(n == 0, "R9 early strobe ignored", n, 0);
        end
        begin
            int n;
            bus_cycle(75, 1'b0, 6'h02, 2);
            count_low(240, n);
            check(n == 0, "R9 early strobe cycle 75", n, 0);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule